// File: doc/BRIEF.md
# Retriggering Acquisition Window Sequencer

This block turns one start pulse into a timed series of converter triggers, each followed by an acquisition-enable window. The timing comes from a small table. Each entry gives a delay, a window length and a repeat count. After a start, the sequencer reads the entries one after another, beginning at address 0. For each entry it issues the requested number of triggers, then moves on to the next entry. It stops at an entry whose delay field is zero, or after the last address.

Software or a host state machine loads the table through a one-word-per-cycle write port while the sequencer is idle. It then pulses start. While the run is in progress, busy stays high. When the run ends, done pulses for one cycle. One clock cycle is 4 ns.

Top module: `acq_retrig_seq`

## Requirements
- R1: After reset, trig, win_en, busy and done are all low, and every table entry reads as zero.
- R2: A table write takes one cycle. It stores tbl_wdata at tbl_waddr. The delay is in bits [15:0], the window length in bits [23:16] and the repeat count in bits [39:24].
- R3: A table write that arrives while busy is high is discarded. A later run behaves as if the write never happened.
- R4: If start is sampled while idle, the first trigger appears exactly delay+3 cycles after the start edge, using the delay of entry 0.
- R5: trig is a one-cycle pulse in the first cycle of the window. win_en stays high for length+1 consecutive cycles.
- R6: Each entry issues repeat+1 triggers. Every trigger after the first waits delay+3 cycles after the cycle in which the previous window closed.
- R7: Entries run in rising address order starting at address 0. The sequencer moves to the next entry only after the current entry has issued all its triggers.
- R8: An entry with a delay of zero ends the run without a trigger. If entry 0 has a delay of zero, done pulses in the cycle after start and no trigger is issued.
- R9: done is high for one cycle when the run ends, and busy is low in that cycle. In a run with triggers, done rises in the same cycle that the last window closes.
- R10: A start pulse that arrives while busy is high has no effect on the run in progress.
- R11: After the entries at address 127 finish, the run ends. The address does not wrap back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 4 ns period |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 7 | Table write address |
| tbl_wdata | input | 40 | Table entry {repeat, length, delay} |
| start | input | 1 | Master start, sampled when idle |
| trig | output | 1 | Converter trigger pulse |
| win_en | output | 1 | Acquisition-enable window |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Every output is registered. The cycle of each event is fixed by the table contents. Take s as the cycle after the start edge. The first trigger is seen at s+delay+3. The window closes length+1 cycles after its trigger. Every later trigger follows the close of the previous window by delay+3 cycles. done appears at the last close, or at s when entry 0 terminates at once. The bench computes these cycles from its own copy of the table and queues each expected event. It samples the outputs on the falling edge and compares each event's kind and cycle number against the head of the queue. Any extra or missing event is reported.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int DLY_W  = 16;
    localparam int LEN_W  = 8;
    localparam int REP_W  = 16;
    localparam int WORD_W = DLY_W + LEN_W + REP_W;
    localparam int TMR_W  = DLY_W + 1;

    typedef struct packed {
        logic [REP_W-1:0] rep;
        logic [LEN_W-1:0] len;
        logic [DLY_W-1:0] dly;
    } entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_WIN
    } st_e;
endpackage

// File: rtl/seq_table.sv
module seq_table
    import seq_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  entry_t        wr_data,
    input  logic          lock,
    input  logic [AW-1:0] rd_addr,
    output entry_t        rd_entry
);
    entry_t mem_d [DEPTH];
    entry_t mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en && !lock && (int'(wr_addr) < DEPTH)) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_entry = mem_q[rd_addr];

    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock) |=> (mem_q[$past(wr_addr)] == $past(mem_q[wr_addr]))); // R3
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  entry_t        rd_entry,
    output logic [AW-1:0] rd_addr,
    output logic          trig_o,
    output logic          win_en_o,
    output logic          busy_o,
    output logic          done_o
);
    typedef struct packed {
        st_e              st;
        logic [AW-1:0]    addr;
        logic [TMR_W-1:0] tmr;
        logic [REP_W-1:0] rep;
        logic             trig;
        logic             done;
    } ctrl_t;

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    ctrl_t r_d, r_q;
    logic  win_last;
    logic  at_last_addr;
    logic [TMR_W-1:0] wait_load;

    always_comb begin
        at_last_addr = (r_q.addr == LAST_ADDR);
        win_last     = (r_q.st == ST_WIN) && (r_q.tmr == '0) && (r_q.rep == '0);
        if (r_q.st == ST_IDLE) begin
            rd_addr = '0;
        end else if (win_last) begin
            rd_addr = r_q.addr + AW'(1);
        end else begin
            rd_addr = r_q.addr;
        end
        wait_load = TMR_W'(rd_entry.dly) + TMR_W'(2);

        r_d      = r_q;
        r_d.trig = 1'b0;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (rd_entry.dly == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = ST_WAIT;
                        r_d.addr = '0;
                        r_d.tmr  = wait_load;
                        r_d.rep  = rd_entry.rep;
                    end
                end
            end
            ST_WAIT: begin
                if (r_q.tmr == '0) begin
                    r_d.st   = ST_WIN;
                    r_d.trig = 1'b1;
                    r_d.tmr  = TMR_W'(rd_entry.len);
                end else begin
                    r_d.tmr = r_q.tmr - TMR_W'(1);
                end
            end
            ST_WIN: begin
                if (r_q.tmr != '0) begin
                    r_d.tmr = r_q.tmr - TMR_W'(1);
                end else if (r_q.rep != '0) begin
                    r_d.rep = r_q.rep - REP_W'(1);
                    r_d.st  = ST_WAIT;
                    r_d.tmr = wait_load;
                end else if (at_last_addr || (rd_entry.dly == '0)) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.addr = r_q.addr + AW'(1);
                    r_d.st   = ST_WAIT;
                    r_d.tmr  = wait_load;
                    r_d.rep  = rd_entry.rep;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign trig_o   = r_q.trig;
    assign win_en_o = (r_q.st == ST_WIN);
    assign busy_o   = (r_q.st != ST_IDLE);
    assign done_o   = r_q.done;

    AST_TRIG_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> win_en_o); // R5
    AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o); // R5
    AST_WIN_OPENS_WITH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_en_o) |-> trig_o); // R5
    AST_GAP_BEFORE_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> !$past(win_en_o)); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R9
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |->
        ((r_q.addr == $past(r_q.addr)) || (r_q.addr == $past(r_q.addr) + AW'(1)))); // R7
endmodule

// File: rtl/acq_retrig_seq.sv
module acq_retrig_seq
    import seq_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_waddr,
    input  logic [WORD_W-1:0] tbl_wdata,
    input  logic              start,
    output logic              trig,
    output logic              win_en,
    output logic              busy,
    output logic              done
);
    entry_t        rd_entry;
    logic [AW-1:0] rd_addr;
    logic          busy_w;

    seq_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_addr  (tbl_waddr),
        .wr_data  (entry_t'(tbl_wdata)),
        .lock     (busy_w),
        .rd_addr  (rd_addr),
        .rd_entry (rd_entry)
    );

    seq_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .rd_entry (rd_entry),
        .rd_addr  (rd_addr),
        .trig_o   (trig),
        .win_en_o (win_en),
        .busy_o   (busy_w),
        .done_o   (done)
    );

    assign busy = busy_w;
endmodule

// File: tb/tb_acq_retrig_seq.sv
module tb_acq_retrig_seq;
    localparam int DEPTH = 128;
    localparam int K_TRIG = 0, K_WEND = 1, K_DONE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [6:0]  tbl_waddr = '0;
    logic [39:0] tbl_wdata = '0;
    logic        start = 1'b0;
    logic        trig, win_en, busy, done;

    int nchk = 0, nerr = 0, cyc = 0;
    bit mon_on = 1'b0, prev_win = 1'b0, finished = 1'b0;
    int sh_d [DEPTH], sh_l [DEPTH], sh_c [DEPTH];
    int eq_kind [$];
    int eq_cyc [$];

    acq_retrig_seq dut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .start(start), .trig(trig), .win_en(win_en),
        .busy(busy), .done(done)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic string kname(input int k);
        return (k == K_TRIG) ? "R4 R6 R7 trigger" : (k == K_WEND) ? "R5 window close" : "R8 R9 R11 done";
    endfunction

    task automatic got(input int kind);
        if (eq_kind.size() == 0) begin
            check(1'b0, {kname(kind), " unexpected"}, cyc, -1);
        end else begin
            int ek = eq_kind.pop_front();
            int ec = eq_cyc.pop_front();
            check(ek == kind, {kname(ek), " event kind"}, kind, ek);
            check(ec == cyc, {kname(ek), " event cycle"}, cyc, ec);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_win && !win_en) got(K_WEND);
            if (done) begin
                got(K_DONE);
                check(busy == 1'b0, "R9 busy low with done", busy, 0);
            end
            if (trig) begin
                got(K_TRIG);
                check(win_en == 1'b1, "R5 trig in window", win_en, 1);
            end
            prev_win = win_en;
        end
    end

    function automatic void push(input int k, input int c);
        eq_kind.push_back(k);
        eq_cyc.push_back(c);
    endfunction

    function automatic void expect_run(input int s);
        int t = s;
        for (int a = 0; a <= DEPTH; a++) begin
            if (a == DEPTH || sh_d[a] == 0) begin
                push(K_DONE, t);
                break;
            end
            for (int r = 0; r <= sh_c[a]; r++) begin
                push(K_TRIG, t + sh_d[a] + 3);
                t = t + sh_d[a] + 3 + sh_l[a] + 1;
                push(K_WEND, t);
            end
        end
    endfunction

    task automatic wr(input int a, input int d, input int l, input int c, input bit shadow);
        @(negedge clk);
        tbl_we = 1'b1;
        tbl_waddr = 7'(a);
        tbl_wdata = {16'(c), 8'(l), 16'(d)};
        if (shadow) begin
            sh_d[a] = d; sh_l[a] = l; sh_c[a] = c;
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic run_seq();
        @(negedge clk);
        start = 1'b1;
        expect_run(cyc + 1);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (eq_kind.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R9 idle after run", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            sh_d[i] = 0; sh_l[i] = 0; sh_c[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(trig == 1'b0, "R1 trig reset", trig, 0);
        check(win_en == 1'b0, "R1 win_en reset", win_en, 0);
        check(busy == 1'b0, "R1 busy reset", busy, 0);
        check(done == 1'b0, "R1 done reset", done, 0);
        mon_on = 1'b1;

        // R8 R1: empty table, entry 0 terminates at once
        run_seq();
        drain();

        // R2 R4 R5: single trigger then terminator
        wr(0, 2, 3, 0, 1'b1);
        run_seq();
        drain();

        // R6 R7: repeats across two entries, terminator at address 2
        wr(0, 5, 1, 2, 1'b1);
        wr(1, 1, 4, 1, 1'b1);
        run_seq();
        repeat (4) @(negedge clk);
        // R10: extra start while busy is ignored
        check(busy == 1'b1, "R10 busy mid-run", busy, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R3: write to address 2 while busy is discarded
        wr(2, 7, 0, 0, 1'b0);
        drain();
        // R3: rerun must still terminate at address 2
        run_seq();
        drain();

        // R11: full table, no wrap after the last address
        for (int a = 0; a < DEPTH; a++) wr(a, 1, 0, 0, 1'b1);
        run_seq();
        drain();

        check(eq_kind.size() == 0, "R7 queue empty", eq_kind.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule